// File: doc/BRIEF.md
# A/B Toggle Update Controller

This block turns three sources of update intent into per-channel update requests for a multi-channel DAC register bank. The first source is a software-written global toggle bit. The second is an external toggle pin that is not synchronous to the core clock. The third is an update-all strobe, which covers both a serial update-all command and a load-pin pulse. For each channel it outputs a one-cycle update enable and a source select that picks input register A or input register B.

The toggle bit and the synchronized pin are ANDed into one toggle level. Only a change of that level triggers anything. A rising change loads the selected channels from B, and a falling change loads them from A. Which channels are "selected" comes from the toggle-select vector. The same vector also decides the source on a plain update-all: unselected channels load A and selected channels load B. If a toggle change and an update-all land in the same cycle, each channel gets one update, and for selected channels the toggle direction decides the source. The register bank treats every enable as a normal update, so a toggle update also wakes a powered-down channel.

Top module: `toggle_update_ctrl`

## Requirements
- R1: After reset `upd_en_o` and `src_b_o` are all zero and the toggle bit is 0. An update-all issued with an all-zero toggle-select vector then loads every channel from A (`src_b_o` = 0).
- R2: A 0-to-1 change of the toggle level (toggle bit AND synchronized pin) produces, two edges after the toggle-bit write, a one-cycle `upd_en_o` equal to `tsel_i` with `src_b_o` equal to `tsel_i` (1 = register B).
- R3: A 1-to-0 change of the toggle level produces a one-cycle `upd_en_o` equal to `tsel_i` with `src_b_o` = 0 (register A).
- R4: A steady toggle level produces no update. This includes rewriting the toggle bit with the value it already holds.
- R5: Channels whose toggle-select bit is 0 never receive an update from a toggle change.
- R6: With the pin low, toggle-bit writes cause no update. With the toggle bit 0, pin changes cause no update.
- R7: A pin change while the toggle bit is 1 passes through `SYNC_STAGES` flops. It yields the R2/R3 update `SYNC_STAGES`+1 edges after the pin moves: a falling pin selects A and a rising pin selects B.
- R8: `upd_all_i` high for one cycle gives, on the next cycle, `upd_en_o` all ones with `src_b_o` equal to `tsel_i`.
- R9: A toggle change and an update-all in the same cycle give one pulse with all channels enabled. Selected channels take the toggle direction's source and unselected channels take A.
- R10: `src_b_o` is never 1 on a channel whose `upd_en_o` bit is 0, and every update pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tsel_i | input | NUM_CH | Toggle-select vector, one bit per channel |
| tgb_we_i | input | 1 | Write strobe for the global toggle bit |
| tgb_wdata_i | input | 1 | Value written to the global toggle bit |
| tgp_async_i | input | 1 | External toggle pin, asynchronous |
| upd_all_i | input | 1 | Update-all strobe (serial command or load pulse) |
| upd_en_o | output | NUM_CH | Per-channel update enable, one-cycle pulse |
| src_b_o | output | NUM_CH | Per-channel source: 1 = register B, 0 = register A |

## Verification
The bench builds the block with NUM_CH = 8 and SYNC_STAGES = 2. Eight channels allow mixed select patterns such as 0xA5 and 0x3C, which expose a swapped or shifted channel bit. Two synchronizer stages fix the pin-to-update latency at three edges, so the bench samples exactly in that cycle. Same-cycle merging is checked by aligning the update-all strobe with the cycle in which the toggle change is detected, once for each edge direction.

// File: rtl/toggle_pkg.sv
package toggle_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2
  } tog_edge_e;
endpackage

// File: rtl/tgp_sync.sv
module tgp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b0;
        else if (i == 0) ff_q[i] <= d_i;
        else ff_q[i] <= ff_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/toggle_edge_det.sv
module toggle_edge_det
  import toggle_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tgb_we_i,
  input  logic      tgb_wdata_i,
  input  logic      tgp_sync_i,
  output logic      lvl_o,
  output tog_edge_e edge_o
);
  logic tgb_q;
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgb_q <= 1'b0;
    else if (tgb_we_i) tgb_q <= tgb_wdata_i;
  end

  // software bit and pin gate each other
  assign lvl_o = tgb_q & tgp_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else lvl_q <= lvl_o;
  end

  always_comb begin
    edge_o = EDGE_NONE;
    if (lvl_o && !lvl_q) edge_o = EDGE_RISE;
    else if (!lvl_o && lvl_q) edge_o = EDGE_FALL;
  end
endmodule

// File: rtl/upd_merge.sv
module upd_merge
  import toggle_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tsel_i,
  input  logic              upd_all_i,
  input  tog_edge_e         edge_i,
  output logic [NUM_CH-1:0] upd_en_o,
  output logic [NUM_CH-1:0] src_b_o
);
  logic tog_hit;
  logic tog_rise;

  assign tog_hit  = (edge_i != EDGE_NONE);
  assign tog_rise = (edge_i == EDGE_RISE);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ch_tog;
      logic en_d;
      logic b_d;

      assign ch_tog = tog_hit & tsel_i[c];
      assign en_d   = ch_tog | upd_all_i;
      // toggle direction wins over plain-update source for selected channels
      assign b_d    = ch_tog ? tog_rise : (upd_all_i & tsel_i[c]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          upd_en_o[c] <= 1'b0;
          src_b_o[c]  <= 1'b0;
        end else begin
          upd_en_o[c] <= en_d;
          src_b_o[c]  <= en_d & b_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/toggle_update_ctrl.sv
module toggle_update_ctrl
  import toggle_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tsel_i,
  input  logic              tgb_we_i,
  input  logic              tgb_wdata_i,
  input  logic              tgp_async_i,
  input  logic              upd_all_i,
  output logic [NUM_CH-1:0] upd_en_o,
  output logic [NUM_CH-1:0] src_b_o
);
  logic      tgp_s;
  logic      tog_lvl;
  tog_edge_e tog_edge;

  tgp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgp_async_i),
    .q_o   (tgp_s)
  );

  toggle_edge_det u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tgb_we_i   (tgb_we_i),
    .tgb_wdata_i(tgb_wdata_i),
    .tgp_sync_i (tgp_s),
    .lvl_o      (tog_lvl),
    .edge_o     (tog_edge)
  );

  upd_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tsel_i   (tsel_i),
    .upd_all_i(upd_all_i),
    .edge_i   (tog_edge),
    .upd_en_o (upd_en_o),
    .src_b_o  (src_b_o)
  );
endmodule

// File: rtl/toggle_update_ctrl_chk.sv
module toggle_update_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] tsel_i,
  input logic              upd_all_i,
  input logic              tog_lvl_i,
  input logic [NUM_CH-1:0] upd_en_o,
  input logic [NUM_CH-1:0] src_b_o
);
  assert_src_in_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_b_o & ~upd_en_o) == '0);

  assert_upd_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_all_i |=> (&upd_en_o));

  assert_rise_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tog_lvl_i) |=> ((upd_en_o & $past(tsel_i)) == $past(tsel_i))
                      && ((src_b_o & $past(tsel_i)) == $past(tsel_i)));

  assert_fall_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tog_lvl_i) |=> ((upd_en_o & $past(tsel_i)) == $past(tsel_i))
                      && ((src_b_o & $past(tsel_i)) == '0));

  assert_steady_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(tog_lvl_i) && !upd_all_i) |=> (upd_en_o == '0));

  assert_unsel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_all_i) |=> ((upd_en_o & ~$past(tsel_i)) == '0));
endmodule

bind toggle_update_ctrl toggle_update_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tsel_i   (tsel_i),
  .upd_all_i(upd_all_i),
  .tog_lvl_i(tog_lvl),
  .upd_en_o (upd_en_o),
  .src_b_o  (src_b_o)
);

// File: tb/sim_toggle_update_ctrl.sv
`timescale 1ns/1ps
module sim_toggle_update_ctrl;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] tsel = '0;
  logic           tgb_we = 1'b0;
  logic           tgb_wd = 1'b0;
  logic           tgp = 1'b1;
  logic           upd_all = 1'b0;
  logic [NCH-1:0] upd_en;
  logic [NCH-1:0] src_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  toggle_update_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tsel_i(tsel), .tgb_we_i(tgb_we),
    .tgb_wdata_i(tgb_wd), .tgp_async_i(tgp), .upd_all_i(upd_all),
    .upd_en_o(upd_en), .src_b_o(src_b)
  );

  task automatic check(input string req, input logic [NCH-1:0] exp_en,
                       input logic [NCH-1:0] exp_b);
    n_chk++;
    if (upd_en !== exp_en || src_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s: en=%h b=%h expected en=%h b=%h", req, upd_en, src_b, exp_en, exp_b);
    end
  endtask

  // write toggle bit at a negedge; result visible two negedges later
  task automatic tgb_write(input logic v, input logic with_all);
    tgb_we = 1'b1; tgb_wd = v;
    @(negedge clk);
    tgb_we = 1'b0; upd_all = with_all;
    @(negedge clk);
    upd_all = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    tgp = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset", '0, '0);
    upd_all = 1'b1; @(negedge clk); upd_all = 1'b0;
    check("R1 A-only after reset", 8'hFF, 8'h00);
    @(negedge clk);
    check("R10 pulse ends", '0, '0);
  endtask

  task automatic t_soft_toggle;
    tsel = 8'hA5;
    tgb_write(1'b1, 1'b0);
    check("R2 tgb rise -> B", 8'hA5, 8'hA5);
    @(negedge clk);
    check("R10 one-cycle", '0, '0);
    tgb_write(1'b1, 1'b0);
    check("R4 same value rewrite", '0, '0);
    tgb_write(1'b0, 1'b0);
    check("R3 tgb fall -> A", 8'hA5, 8'h00);
    tsel = 8'h00;
    tgb_write(1'b1, 1'b0);
    check("R5 no selected channels", '0, '0);
    tgb_write(1'b0, 1'b0);
    check("R5 no selected channels fall", '0, '0);
  endtask

  task automatic t_update_all;
    tsel = 8'h3C;
    upd_all = 1'b1; @(negedge clk); upd_all = 1'b0;
    check("R8 update-all per tsel", 8'hFF, 8'h3C);
  endtask

  task automatic t_merge;
    tsel = 8'h0F;
    tgb_write(1'b1, 1'b1);
    check("R9 merge rise", 8'hFF, 8'h0F);
    @(negedge clk);
    check("R9 single pulse", '0, '0);
    tgb_write(1'b0, 1'b1);
    check("R9 merge fall", 8'hFF, 8'h00);
  endtask

  task automatic t_pin;
    tsel = 8'h5A;
    pin_set(1'b0);
    check("R6 pin fall with tgb 0", '0, '0);
    pin_set(1'b1);
    check("R6 pin rise with tgb 0", '0, '0);
    tgb_write(1'b1, 1'b0);
    check("R2 tgb rise with pin high", 8'h5A, 8'h5A);
    pin_set(1'b0);
    check("R7 pin fall -> A", 8'h5A, 8'h00);
    @(negedge clk);
    check("R10 pin pulse ends", '0, '0);
    pin_set(1'b1);
    check("R7 pin rise -> B", 8'h5A, 8'h5A);
    pin_set(1'b0);
    check("R7 pin fall again", 8'h5A, 8'h00);
    tgb_write(1'b0, 1'b0);
    check("R6 tgb fall with pin low", '0, '0);
    tgb_write(1'b1, 1'b0);
    check("R6 tgb rise with pin low", '0, '0);
    repeat (4) @(negedge clk);
    check("R4 steady level", '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_soft_toggle();
    t_update_all();
    t_merge();
    t_pin();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule